// File: doc/BRIEF.md
# E1 Sa-Bit Extractor and Multiframe Buffer

This block sits behind an E1 receive framer. It watches the aligned receive bit stream and picks out the five national bits (Sa4 to Sa8) from time slot 0 of the frames that do not carry the frame alignment word. These are the odd-numbered frames of a 16-frame multiframe. Three views of those bits are kept at the same time.

The first view is a latest-value register that holds the five Sa bits of the most recent such frame. The second is a 40-bit multiframe copy: for each Sa bit, the eight values it took across one complete multiframe. The third is a serial bit stream with a valid strobe. It carries only the Sa bits that a 5-bit enable mask selects, and it feeds a shared receive FIFO path. A downstream receiver can treat that stream as transparent bits or can decode HDLC frames from it.

The framer supplies a frame-start strobe, a multiframe-start strobe and an alignment flag. When alignment is lost, capture stops. It starts again only at the next multiframe start.

Top module: `sa_extract`

## Requirements
- R1: While reset is asserted, and until the first Sa bit is captured, `saLatest`, `mfCopy`, `mfReady`, `fifoBit` and `fifoValid` are all zero.
- R2: Sa bits are taken only from time slot 0 of odd frames within the multiframe (frame 0 is the frame flagged by `mfStart`). The octet of a frame flagged by `frameStart` is sent bit 1 first, and Sa4..Sa8 are octet bits 4..8 (the 4th to 8th bits after `frameStart`). Time slot 0 of even frames has no effect on any output.
- R3: `saLatest` holds the most recent Sa bits, with Sa4 in bit 0 through Sa8 in bit 4. It changes only in the cycle after the Sa8 bit of an odd frame arrives.
- R4: At each multiframe start, `mfCopy` takes the multiframe just ended. Bits [8i+7:8i] belong to Sa(4+i), and bit k of that field comes from frame 2k+1. `mfReady` is high for exactly the one cycle after that start.
- R5: `mfCopy` and `mfReady` are updated only for a multiframe that was captured in full: no transfer happens at the first multiframe start after reset, or at the first start after alignment is regained.
- R6: One cycle after each Sa bit whose bit in `saEnable` is set (bit 0 = Sa4 ... bit 4 = Sa8), `fifoValid` is high and `fifoBit` carries that bit. Within a frame, the bits come out in ascending order from Sa4 to Sa8.
- R7: With `saEnable` all zero, `fifoValid` stays low. `saLatest` and `mfCopy` are still updated.
- R8: While `aligned` is low, and until the next `mfStart` seen with `aligned` high, `fifoValid` stays low and `saLatest` holds its value. The partly captured multiframe is never transferred.
- R9: Bits outside time slot 0 never reach `fifoBit`, `saLatest` or `mfCopy`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, one received bit per cycle |
| rstN | input | 1 | Asynchronous active-low reset |
| rxBit | input | 1 | Aligned receive data bit |
| frameStart | input | 1 | High with bit 1 of time slot 0 of each frame |
| mfStart | input | 1 | High together with `frameStart` on frame 0 of a multiframe |
| aligned | input | 1 | Frame alignment is held by the framer |
| saEnable | input | 5 | Selects which Sa bits go to the serial output (bit 0 = Sa4) |
| saLatest | output | 5 | Sa bits of the most recent odd frame |
| mfCopy | output | 40 | One multiframe of each Sa bit, 8 bits per Sa bit |
| mfReady | output | 1 | One-cycle pulse when `mfCopy` is refreshed |
| fifoBit | output | 1 | Serial Sa bit toward the receive FIFO path |
| fifoValid | output | 1 | `fifoBit` is valid this cycle |

## Verification
The hardest situation to reach is an alignment loss partway through a multiframe. After it, the block must drop the partial capture, skip one transfer, and resume cleanly at a later multiframe start. The bench drops `aligned` for two frames in the middle of a multiframe. It then checks that the serial count stops after the third odd frame, that `saLatest` freezes, and that the next boundary produces no `mfReady`. The boundary after that must deliver a complete copy. Each frame carries a distinct Sa pattern, and the even frames carry a nonzero pattern in the Sa positions, so any confusion of positions or frames shows up in the values.

// File: rtl/sa_pkg.sv
package sa_pkg;
  // Number of national bits per odd frame and zero-based position of Sa4
  localparam int SA_COUNT = 5;
  localparam int SA_POS_FIRST = 3;

  // Strobes from control to datapath
  typedef struct packed {
    logic       saPulse;   // current rxBit is a captured Sa bit
    logic [2:0] saSel;     // which Sa bit (0 = Sa4)
    logic       commit;    // last Sa bit of the frame: refresh latest register
    logic       transfer;  // multiframe boundary: move working set to copy
  } saStrb_t;
endpackage

// File: rtl/sa_ctrl.sv
module sa_ctrl
  import sa_pkg::*;
#(
  parameter int MF_FRAMES = 16,
  localparam int FRAME_W = $clog2(MF_FRAMES),
  localparam int SLOT_W = $clog2(MF_FRAMES / 2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              mfStart,
  input  logic              aligned,
  output saStrb_t           strb,
  output logic [SLOT_W-1:0] slot
);
  localparam logic [3:0] POS_LO = 4'(SA_POS_FIRST);
  localparam logic [3:0] POS_HI = 4'(SA_POS_FIRST + SA_COUNT - 1);
  localparam logic [3:0] POS_SAT = 4'(SA_POS_FIRST + SA_COUNT);

  logic [3:0]         bitCnt;
  logic [FRAME_W-1:0] frameCnt;
  logic               run;
  logic [3:0]         bitPos;
  logic [FRAME_W-1:0] curFrame;
  logic               inSa;

  always_comb begin
    bitPos = frameStart ? 4'd0 : bitCnt;
    if (frameStart) curFrame = mfStart ? '0 : frameCnt + 1'b1;
    else            curFrame = frameCnt;
    inSa = (bitPos >= POS_LO) && (bitPos <= POS_HI) && curFrame[0];
    strb.saPulse  = inSa && run && aligned;
    strb.saSel    = 3'(bitPos - POS_LO);
    strb.commit   = strb.saPulse && (bitPos == POS_HI);
    strb.transfer = frameStart && mfStart && run && aligned;
    slot = curFrame[FRAME_W-1:1];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      frameCnt <= '0;
      run      <= 1'b0;
    end else begin
      bitCnt   <= (bitPos == POS_SAT) ? bitPos : bitPos + 4'd1;
      frameCnt <= curFrame;
      if (!aligned)                    run <= 1'b0;
      else if (frameStart && mfStart)  run <= 1'b1;
    end
  end

  // R2: Sa bits never coincide with the first bit of a frame, and need alignment
  a_r2_sa_in_ts0: assert property (@(posedge clk) disable iff (!rstN)
    strb.saPulse |-> (!frameStart && aligned));
  // R8: a cycle without alignment blocks the boundary transfer that follows
  a_r8_no_transfer_after_loss: assert property (@(posedge clk) disable iff (!rstN)
    !aligned |=> !strb.transfer);
  // R4: capture and transfer never happen in the same cycle
  a_r4_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.saPulse, strb.transfer}));
endmodule

// File: rtl/sa_datapath.sv
module sa_datapath
  import sa_pkg::*;
#(
  parameter int NFAS = 8,
  parameter int SLOT_W = 3
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rxBit,
  input  logic [SA_COUNT-1:0]      saEnable,
  input  saStrb_t                  strb,
  input  logic [SLOT_W-1:0]        slot,
  output logic [SA_COUNT-1:0]      saLatest,
  output logic [SA_COUNT*NFAS-1:0] mfCopy,
  output logic                     mfReady,
  output logic                     fifoBit,
  output logic                     fifoValid
);
  logic [SA_COUNT-2:0] partial;

  for (genvar i = 0; i < SA_COUNT; i++) begin : g_sa
    logic [NFAS-1:0] work;
    logic [NFAS-1:0] copy;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        work <= '0;
        copy <= '0;
      end else begin
        if (strb.saPulse && strb.saSel == 3'(i)) work[slot] <= rxBit;
        if (strb.transfer) copy <= work;
      end
    end
    assign mfCopy[i*NFAS +: NFAS] = copy;

    if (i < SA_COUNT - 1) begin : g_part
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) partial[i] <= 1'b0;
        else if (strb.saPulse && strb.saSel == 3'(i)) partial[i] <= rxBit;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      saLatest  <= '0;
      mfReady   <= 1'b0;
      fifoBit   <= 1'b0;
      fifoValid <= 1'b0;
    end else begin
      if (strb.commit) saLatest <= {rxBit, partial};
      mfReady   <= strb.transfer;
      fifoValid <= strb.saPulse && saEnable[strb.saSel];
      fifoBit   <= strb.saPulse ? rxBit : 1'b0;
    end
  end

  // R6: every serial bit follows a captured Sa bit
  a_r6_fifo_follows_sa: assert property (@(posedge clk) disable iff (!rstN)
    fifoValid |-> $past(strb.saPulse));
  // R7: an empty mask yields no serial bit
  a_r7_empty_mask: assert property (@(posedge clk) disable iff (!rstN)
    (saEnable == '0) |=> !fifoValid);
  // R3: the latest register only moves on the last Sa bit of a frame
  a_r3_latest_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(saLatest));
  // R4: the multiframe copy only moves at a boundary transfer
  a_r4_copy_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.transfer |=> $stable(mfCopy));
endmodule

// File: rtl/sa_extract.sv
module sa_extract
  import sa_pkg::*;
#(
  parameter int MF_FRAMES = 16,
  localparam int NFAS = MF_FRAMES / 2,
  localparam int SLOT_W = $clog2(NFAS)
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     rxBit,
  input  logic                     frameStart,
  input  logic                     mfStart,
  input  logic                     aligned,
  input  logic [SA_COUNT-1:0]      saEnable,
  output logic [SA_COUNT-1:0]      saLatest,
  output logic [SA_COUNT*NFAS-1:0] mfCopy,
  output logic                     mfReady,
  output logic                     fifoBit,
  output logic                     fifoValid
);
  saStrb_t           strb;
  logic [SLOT_W-1:0] slot;

  sa_ctrl #(.MF_FRAMES(MF_FRAMES)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .mfStart(mfStart),
    .aligned(aligned), .strb(strb), .slot(slot)
  );

  sa_datapath #(.NFAS(NFAS), .SLOT_W(SLOT_W)) u_dp (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .saEnable(saEnable), .strb(strb),
    .slot(slot), .saLatest(saLatest), .mfCopy(mfCopy), .mfReady(mfReady),
    .fifoBit(fifoBit), .fifoValid(fifoValid)
  );
endmodule

// File: tb/sa_extract_bench.sv
module sa_extract_bench;
  logic clk = 1'b0, rstN = 1'b0, rxBit = 1'b0;
  logic frameStart = 1'b0, mfStart = 1'b0, aligned = 1'b0;
  logic [4:0] saEnable = 5'd0;
  logic [4:0] saLatest;
  logic [39:0] mfCopy;
  logic mfReady, fifoBit, fifoValid;

  sa_extract u_sa_extract (
    .clk(clk), .rstN(rstN), .rxBit(rxBit), .frameStart(frameStart),
    .mfStart(mfStart), .aligned(aligned), .saEnable(saEnable),
    .saLatest(saLatest), .mfCopy(mfCopy), .mfReady(mfReady),
    .fifoBit(fifoBit), .fifoValid(fifoValid)
  );

  always #4 clk = ~clk;  // 125 MHz

  int checks = 0, fails = 0;
  logic fifoLog [0:127];
  int fifoCnt = 0, readyCnt = 0;
  logic [39:0] lastCopy = '0;
  logic [4:0] latestAfterFas = '0;
  bit done = 0;

  always @(negedge clk) begin
    if (fifoValid) begin
      if (fifoCnt < 128) fifoLog[fifoCnt] = fifoBit;
      fifoCnt++;
    end
    if (mfReady) begin
      readyCnt++;
      lastCopy = mfCopy;
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp,
                       input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] saOf(input int seed, input int k);
    return 5'((seed * 11 + k * 7 + k * k * 3) ^ (seed * 5 + 2));
  endfunction

  function automatic logic [39:0] expCopy(input int seed);
    logic [39:0] c = '0;
    for (int k = 0; k < 8; k++) begin
      logic [4:0] s = saOf(seed, k);
      for (int i = 0; i < 5; i++) c[i*8 + k] = s[i];
    end
    return c;
  endfunction

  // bit 1 of the octet is ts0[7]; Sa4..Sa8 land in ts0[4..0]
  function automatic logic [7:0] nfasOctet(input logic [4:0] s);
    return {3'b110, s[0], s[1], s[2], s[3], s[4]};
  endfunction

  task automatic sendFrame(input logic [7:0] ts0, input bit mfs, input bit al, input int f);
    for (int b = 0; b < 256; b++) begin
      rxBit = (b < 8) ? ts0[7-b] : ((b + f) % 3 == 0);
      frameStart = (b == 0);
      mfStart = mfs && (b == 0);
      aligned = al;
      @(posedge clk);
      @(negedge clk);
      #1;
    end
  endtask

  task automatic sendMf(input int seed, input int dropFrom);
    for (int f = 0; f < 16; f++) begin
      bit al = !(dropFrom >= 0 && f >= dropFrom && f < dropFrom + 2);
      logic [7:0] ts0 = (f % 2 == 1) ? nfasOctet(saOf(seed, f / 2)) : 8'b10011011;
      sendFrame(ts0, f == 0, al, f);
      if (f == 0) latestAfterFas = saLatest;
    end
  endtask

  task automatic checkFifo(input int seed, input logic [4:0] mask, input int nfas,
                           input string req);
    int n = 0;
    for (int k = 0; k < nfas; k++) begin
      logic [4:0] s = saOf(seed, k);
      for (int i = 0; i < 5; i++) begin
        if (mask[i]) begin
          if (n < 128) check(req, 64'(fifoLog[n]), 64'(s[i]), "serial bit value/order");
          n++;
        end
      end
    end
    check(req, 64'(fifoCnt), 64'(n), "serial bit count");
  endtask

  task automatic testReset();
    repeat (3) @(negedge clk);
    check("R1", 64'({saLatest, mfReady, fifoBit, fifoValid}), 64'd0, "outputs in reset");
    check("R1", 64'(mfCopy), 64'd0, "copy in reset");
    rstN = 1'b1;
    @(negedge clk); #1;
    check("R1", 64'({saLatest, mfReady, fifoValid}), 64'd0, "outputs after reset");
  endtask

  task automatic testAllBits();
    saEnable = 5'b11111; fifoCnt = 0;
    sendMf(1, -1);
    checkFifo(1, 5'b11111, 8, "R6 R9");
    check("R3", 64'(saLatest), 64'(saOf(1, 7)), "latest after multiframe");
    check("R5", 64'(readyCnt), 64'd0, "no transfer at first start");
    check("R1", 64'(mfCopy), 64'd0, "copy before first transfer");
    fifoCnt = 0;
    sendMf(2, -1);
    check("R4", 64'(readyCnt), 64'd1, "one transfer");
    check("R4", 64'(lastCopy), 64'(expCopy(1)), "copy of first multiframe");
    check("R2", 64'(latestAfterFas), 64'(saOf(1, 7)), "even frame leaves latest");
    checkFifo(2, 5'b11111, 8, "R6");
  endtask

  task automatic testSubset();
    saEnable = 5'b10101; fifoCnt = 0;
    sendMf(3, -1);
    checkFifo(3, 5'b10101, 8, "R6");
    check("R4", 64'(readyCnt), 64'd2, "transfer count");
    check("R4", 64'(lastCopy), 64'(expCopy(2)), "copy of second multiframe");
    check("R2", 64'(latestAfterFas), 64'(saOf(2, 7)), "even frame leaves latest");
  endtask

  task automatic testZeroMask();
    saEnable = 5'b00000; fifoCnt = 0;
    sendMf(4, -1);
    check("R7", 64'(fifoCnt), 64'd0, "no serial bits with empty mask");
    check("R7", 64'(saLatest), 64'(saOf(4, 7)), "latest still updated");
    check("R9", 64'(lastCopy), 64'(expCopy(3)), "copy unaffected by other slots");
  endtask

  task automatic testAlignLoss();
    saEnable = 5'b11111; fifoCnt = 0;
    sendMf(5, 6);
    check("R4", 64'(lastCopy), 64'(expCopy(4)), "copy before loss");
    check("R8", 64'(readyCnt), 64'd4, "transfer count before loss");
    checkFifo(5, 5'b11111, 3, "R8");
    check("R8", 64'(saLatest), 64'(saOf(5, 2)), "latest frozen after loss");
    fifoCnt = 0;
    sendMf(6, -1);
    check("R8", 64'(readyCnt), 64'd4, "partial multiframe not transferred");
    check("R5", 64'(lastCopy), 64'(expCopy(4)), "copy held over partial multiframe");
    checkFifo(6, 5'b11111, 8, "R8");
    fifoCnt = 0;
    sendMf(7, -1);
    check("R5", 64'(readyCnt), 64'd5, "transfer resumes");
    check("R5", 64'(lastCopy), 64'(expCopy(6)), "copy after resume");
  endtask

  initial begin
    testReset();
    testAllBits();
    testSubset();
    testZeroMask();
    testAlignLoss();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 190000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule